// File: doc/BRIEF.md
# Companded PCM Attenuator and Idle Inserter

This block sits on the decoder output path of a multi-channel voice transcoder. Each channel receives one 8-bit companded PCM sample per 8 kHz frame. The block returns that sample unchanged, lowers it by 6 dB or 12 dB, or replaces it with the out-of-service idle code. A shared law input selects A-law or mu-law coding. To attenuate, the block expands the code to a signed linear value, shifts it right arithmetically, and compresses the result again. Serialisation of the sample and the ADPCM arithmetic lie outside this block.

Each channel has its own 2-bit loss selector, frame sync, mute input and sample strobe. The selector is sampled only when that channel's frame sync rises, so a selector that changes between frames has no effect until the next frame boundary. The mute input forces the silence code on the sample it accompanies. The result is held in a register and changes only when a new sample is presented.

Top module: `pcm_gain_idle`

## Requirements
- R1: After reset every `out_valid` bit is 0, every `smp_out` byte is 0x00, and every channel's loss selector is 00, so samples pass through until the first frame sync.
- R2: With an effective selector of 00 and mute low, the output equals the input code bit for bit, for all 256 codes under both laws.
- R3: Selector 01 gives 6 dB loss. The code is expanded to linear, shifted right arithmetically by one place, and compressed again under the same law.
- R4: Selector 10 gives 12 dB loss in the same way, with an arithmetic right shift by two places.
- R5: `law_sel`=1 selects A-law and `law_sel`=0 selects mu-law. In A-law the code is XORed with 0x55, bit 7 set means positive, bits 6:4 give the segment e and bits 3:0 the step m. The magnitude is 2m+1 for e=0 and (2m+33)<<(e-1) otherwise. In mu-law the code is complemented, bit 7 set means negative, and the magnitude is ((2m+33)<<e)-33. Compression chooses the segment that contains the magnitude (in mu-law the magnitude plus 33), keeps the four bits below its leading one, encodes zero as positive, and clips at 4095 (A-law) or 8158 (mu-law).
- R6: Selector 11 replaces the sample with the idle code: 0xFF in mu-law and 0xD5 in A-law.
- R7: A channel's selector is captured from `pad_ctrl` only in a cycle where that channel's `frame_sync` is high after being low the cycle before. A sample strobed in that same cycle already uses the new selector. Changes to `pad_ctrl` at any other time have no effect.
- R8: With `mute` high alongside the sample strobe, the output is the silence code (0xFF in mu-law, 0xD5 in A-law), whatever the selector.
- R9: `out_valid` goes high for exactly the cycle after a strobe. `smp_out` is updated only at a strobe and holds otherwise.
- R10: Channels are independent. Each channel's output depends only on its own selector, sync, mute, strobe and sample, together with the shared law input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| law_sel | input | 1 | 1 = A-law, 0 = mu-law |
| frame_sync | input | NUM_CH | Per-channel PCM-side frame sync; a rising edge captures the selector |
| pad_ctrl | input | 2*NUM_CH | Per-channel loss selector, channel i at bits [2i+1:2i] |
| mute | input | NUM_CH | Per-channel mute, sampled with the strobe |
| smp_valid | input | NUM_CH | Per-channel sample strobe |
| smp_in | input | 8*NUM_CH | Per-channel companded input, channel i at bits [8i+7:8i] |
| smp_out | output | 8*NUM_CH | Per-channel registered companded output |
| out_valid | output | NUM_CH | Per-channel output strobe, one cycle after `smp_valid` |

## Verification
Two events can coincide in one cycle: a selector capture at a frame-sync rising edge, and a sample strobe. A mute can also coincide with both. The bench raises `frame_sync` in the same cycle as `smp_valid`, with a selector different from the one held. It expects the output to reflect the new selector, and it expects mute to win when mute is also raised in that cycle. It also holds `frame_sync` high while changing `pad_ctrl`, and it judges from the next sample's value that the level alone captures nothing.

// File: rtl/pgi_pkg.sv
package pgi_pkg;
  localparam int CODE_W = 8;
  localparam int LIN_W  = 14;
  localparam int CTRL_W = 2;

  typedef logic [CODE_W-1:0]       code_t;
  typedef logic signed [LIN_W-1:0] lin_t;

  typedef enum logic [CTRL_W-1:0] {
    PAD_NONE = 2'b00,
    PAD_6DB  = 2'b01,
    PAD_12DB = 2'b10,
    PAD_IDLE = 2'b11
  } pad_e;

  localparam code_t MU_IDLE = 8'hFF;
  localparam code_t A_IDLE  = 8'hD5;
  localparam logic [12:0] MU_CLIP = 13'd8158;
  localparam logic [12:0] A_CLIP  = 13'd4095;

  function automatic code_t idle_code(input logic a_law);
    return a_law ? A_IDLE : MU_IDLE;
  endfunction

  // index of the highest set bit
  function automatic logic [3:0] top_bit(input logic [12:0] v);
    logic [3:0] p;
    p = 4'd0;
    for (int i = 0; i < 13; i++) begin
      if (v[i]) p = 4'(i);
    end
    return p;
  endfunction

  function automatic lin_t expand(input code_t c, input logic a_law);
    code_t       u;
    logic        neg;
    logic [2:0]  e;
    logic [3:0]  m;
    logic [12:0] mag;
    if (a_law) begin
      u   = c ^ 8'h55;
      neg = ~u[7];
      e   = u[6:4];
      m   = u[3:0];
      if (e == 3'd0) mag = 13'({m, 1'b1});
      else           mag = (13'({m, 1'b1}) + 13'd32) << (e - 3'd1);
    end else begin
      u   = ~c;
      neg = u[7];
      e   = u[6:4];
      m   = u[3:0];
      mag = ((13'({m, 1'b1}) + 13'd32) << e) - 13'd33;
    end
    return neg ? -lin_t'({1'b0, mag}) : lin_t'({1'b0, mag});
  endfunction

  function automatic code_t compress(input lin_t x, input logic a_law);
    logic        neg;
    logic [13:0] absx;
    logic [12:0] mag;
    logic [12:0] t;
    logic [3:0]  e;
    logic [3:0]  mant;
    neg  = x[LIN_W-1];
    absx = neg ? 14'(-x) : 14'(x);
    mag  = absx[12:0];
    if (a_law) begin
      if (mag > A_CLIP) mag = A_CLIP;
      if (mag < 13'd32) begin
        e    = 4'd0;
        mant = mag[4:1];
      end else begin
        e    = top_bit(mag) - 4'd4;
        mant = 4'(mag >> e);
      end
      return {~neg, e[2:0], mant} ^ 8'h55;
    end else begin
      if (mag > MU_CLIP) mag = MU_CLIP;
      t    = mag + 13'd33;
      e    = top_bit(t) - 4'd5;
      mant = 4'(t >> (e + 4'd1));
      return ~{neg, e[2:0], mant};
    end
  endfunction

  function automatic lin_t apply_loss(input lin_t x, input pad_e p);
    case (p)
      PAD_6DB:  return x >>> 1;
      PAD_12DB: return x >>> 2;
      default:  return x;
    endcase
  endfunction
endpackage

// File: rtl/pgi_ctrl_latch.sv
module pgi_ctrl_latch
  import pgi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_in,
  input  logic [CTRL_W-1:0] ctrl_in,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [CTRL_W-1:0] ctrl_eff,
  output logic              sync_rise
);
  logic sync_d;

  assign sync_rise = sync_in & ~sync_d;
  assign ctrl_eff  = sync_rise ? ctrl_in : ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_d <= 1'b0;
      ctrl_q <= '0;
    end else begin
      sync_d <= sync_in;
      if (sync_rise) ctrl_q <= ctrl_in;
    end
  end
endmodule

// File: rtl/pgi_gain.sv
module pgi_gain
  import pgi_pkg::*;
(
  input  logic              a_law,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic              mute,
  input  code_t             code_in,
  output code_t             code_out
);
  pad_e  sel;
  lin_t  lin_in;
  lin_t  lin_att;
  code_t att_code;

  assign sel      = pad_e'(ctrl);
  assign lin_in   = expand(code_in, a_law);
  assign lin_att  = apply_loss(lin_in, sel);
  assign att_code = compress(lin_att, a_law);

  always_comb begin
    if (mute || sel == PAD_IDLE) code_out = idle_code(a_law);
    else if (sel == PAD_NONE)    code_out = code_in;
    else                         code_out = att_code;
  end
endmodule

// File: rtl/pgi_out_reg.sv
module pgi_out_reg
  import pgi_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  valid_in,
  input  code_t data_in,
  output logic  valid_out,
  output code_t data_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_out <= 1'b0;
      data_out  <= '0;
    end else begin
      valid_out <= valid_in;
      if (valid_in) data_out <= data_in;
    end
  end
endmodule

// File: rtl/pcm_gain_idle.sv
module pcm_gain_idle
  import pgi_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       law_sel,
  input  logic [NUM_CH-1:0]          frame_sync,
  input  logic [NUM_CH*CTRL_W-1:0]   pad_ctrl,
  input  logic [NUM_CH-1:0]          mute,
  input  logic [NUM_CH-1:0]          smp_valid,
  input  logic [NUM_CH*CODE_W-1:0]   smp_in,
  output logic [NUM_CH*CODE_W-1:0]   smp_out,
  output logic [NUM_CH-1:0]          out_valid
);
  // named internal events, brought out for the checker
  logic [NUM_CH-1:0]        fs_rise_w;
  logic [NUM_CH*CTRL_W-1:0] ctrl_q_w;
  logic [NUM_CH*CTRL_W-1:0] ctrl_eff_w;
  logic [NUM_CH*CODE_W-1:0] next_code_w;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    pgi_ctrl_latch u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .sync_in   (frame_sync[i]),
      .ctrl_in   (pad_ctrl[i*CTRL_W +: CTRL_W]),
      .ctrl_q    (ctrl_q_w[i*CTRL_W +: CTRL_W]),
      .ctrl_eff  (ctrl_eff_w[i*CTRL_W +: CTRL_W]),
      .sync_rise (fs_rise_w[i])
    );

    pgi_gain u_gain (
      .a_law    (law_sel),
      .ctrl     (ctrl_eff_w[i*CTRL_W +: CTRL_W]),
      .mute     (mute[i]),
      .code_in  (smp_in[i*CODE_W +: CODE_W]),
      .code_out (next_code_w[i*CODE_W +: CODE_W])
    );

    pgi_out_reg u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .valid_in  (smp_valid[i]),
      .data_in   (next_code_w[i*CODE_W +: CODE_W]),
      .valid_out (out_valid[i]),
      .data_out  (smp_out[i*CODE_W +: CODE_W])
    );
  end
endmodule

// File: rtl/pgi_checker.sv
module pgi_checker
  import pgi_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     law_sel,
  input logic [NUM_CH-1:0]        mute,
  input logic [NUM_CH-1:0]        smp_valid,
  input logic [NUM_CH*CODE_W-1:0] smp_in,
  input logic [NUM_CH*CODE_W-1:0] smp_out,
  input logic [NUM_CH-1:0]        out_valid,
  input logic [NUM_CH*CTRL_W-1:0] pad_ctrl,
  input logic [NUM_CH-1:0]        fs_rise_w,
  input logic [NUM_CH*CTRL_W-1:0] ctrl_q_w
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    AST_CTRL_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      fs_rise_w[i] |=> ctrl_q_w[i*CTRL_W +: CTRL_W] == $past(pad_ctrl[i*CTRL_W +: CTRL_W])); // R7
    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !fs_rise_w[i] |=> $stable(ctrl_q_w[i*CTRL_W +: CTRL_W])); // R7
    AST_STROBE_ON: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid[i] |=> out_valid[i]); // R9
    AST_STROBE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_valid[i] |=> !out_valid[i]); // R9
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_valid[i] |=> $stable(smp_out[i*CODE_W +: CODE_W])); // R9
    AST_MUTE_SILENCE: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid[i] && mute[i]) |=>
        smp_out[i*CODE_W +: CODE_W] == ($past(law_sel) ? A_IDLE : MU_IDLE)); // R8
    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid[i] && !mute[i] && !fs_rise_w[i] && ctrl_q_w[i*CTRL_W +: CTRL_W] == 2'b00) |=>
        smp_out[i*CODE_W +: CODE_W] == $past(smp_in[i*CODE_W +: CODE_W])); // R2
    AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid[i] && !fs_rise_w[i] && ctrl_q_w[i*CTRL_W +: CTRL_W] == 2'b11) |=>
        smp_out[i*CODE_W +: CODE_W] == ($past(law_sel) ? A_IDLE : MU_IDLE)); // R6
  end
endmodule

bind pcm_gain_idle pgi_checker #(.NUM_CH(NUM_CH)) u_pgi_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .law_sel   (law_sel),
  .mute      (mute),
  .smp_valid (smp_valid),
  .smp_in    (smp_in),
  .smp_out   (smp_out),
  .out_valid (out_valid),
  .pad_ctrl  (pad_ctrl),
  .fs_rise_w (fs_rise_w),
  .ctrl_q_w  (ctrl_q_w)
);

// File: tb/pcm_gain_idle_test.sv
module pcm_gain_idle_test;
  localparam int NCH = 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             law_sel = 1'b0;
  logic [NCH-1:0]   frame_sync = '0;
  logic [NCH*2-1:0] pad_ctrl = '0;
  logic [NCH-1:0]   mute = '0;
  logic [NCH-1:0]   smp_valid = '0;
  logic [NCH*8-1:0] smp_in = '0;
  logic [NCH*8-1:0] smp_out;
  logic [NCH-1:0]   out_valid;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pcm_gain_idle #(.NUM_CH(NCH)) uut (
    .clk(clk), .rst_n(rst_n), .law_sel(law_sel), .frame_sync(frame_sync),
    .pad_ctrl(pad_ctrl), .mute(mute), .smp_valid(smp_valid), .smp_in(smp_in),
    .smp_out(smp_out), .out_valid(out_valid)
  );

  // ---- reference arithmetic (from the requirements) ----
  function automatic int ref_expand(input int c, input bit a);
    int u, e, m, mag;
    bit neg;
    if (a) begin
      u = c ^ 'h55; neg = (u < 128); e = (u / 16) % 8; m = u % 16;
      mag = (e == 0) ? 2*m + 1 : (2*m + 33) * (1 << (e - 1));
    end else begin
      u = 255 - c; neg = (u >= 128); e = (u / 16) % 8; m = u % 16;
      mag = (2*m + 33) * (1 << e) - 33;
    end
    return neg ? -mag : mag;
  endfunction

  function automatic int ref_compress(input int x, input bit a);
    int mag, e, mant, t;
    bit neg;
    neg = (x < 0);
    mag = neg ? -x : x;
    if (a) begin
      if (mag > 4095) mag = 4095;
      if (mag < 32) begin e = 0; mant = (mag / 2) % 16; end
      else begin
        e = 1;
        while (e < 7 && mag >= (32 << e)) e++;
        mant = (mag >> e) % 16;
      end
      return ((neg ? 0 : 128) + 16*e + mant) ^ 'h55;
    end else begin
      if (mag > 8158) mag = 8158;
      t = mag + 33; e = 0;
      while (e < 7 && t >= (64 << e)) e++;
      mant = (t >> (e + 1)) % 16;
      return 255 - ((neg ? 128 : 0) + 16*e + mant);
    end
  endfunction

  function automatic int ref_out(input int c, input int ctl, input bit a, input bit mu);
    int idle;
    idle = a ? 'hD5 : 'hFF;
    if (mu || ctl == 3) return idle;
    if (ctl == 0) return c;
    return ref_compress(ref_expand(c, a) >>> ctl, a);
  endfunction

  function automatic string tag_of(input int ctl);
    case (ctl)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic pulse_sync(input int c0, input int c1);
    pad_ctrl = {2'(c1), 2'(c0)};
    frame_sync = '1;
    @(negedge clk);
    frame_sync = '0;
    @(negedge clk);
  endtask

  task automatic strobe(input int c0, input int c1);
    smp_in = {8'(c1), 8'(c0)};
    smp_valid = '1;
    @(negedge clk);
    smp_valid = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 out_valid", int'(out_valid), 0);
    check("R1 smp_out", int'(smp_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 default selector passes, no sync seen yet
    strobe('h3C, 'h81);
    check("R1 ch0 default pass", int'(smp_out[7:0]), 'h3C);
    check("R1 ch1 default pass", int'(smp_out[15:8]), 'h81);
    check("R9 out_valid after strobe", int'(out_valid), 3);

    // main sweep: both laws, all selectors, all codes; channels differ (R10, R5)
    for (int a = 0; a < 2; a++) begin
      law_sel = 1'(a);
      for (int k = 0; k < 4; k++) begin
        pulse_sync(k, 3 - k);
        for (int c = 0; c < 256; c++) begin
          strobe(c, 255 - c);
          check({tag_of(k), " R5 R10 ch0"}, int'(smp_out[7:0]), ref_out(c, k, 1'(a), 1'b0));
          check({tag_of(3 - k), " R5 R10 ch1"}, int'(smp_out[15:8]), ref_out(255 - c, 3 - k, 1'(a), 1'b0));
        end
      end
    end

    // R9 hold: no strobe, input moves, output stays
    law_sel = 1'b0;
    pulse_sync(2, 1);
    strobe('h12, 'h9A);
    smp_in = 16'h5555;
    @(negedge clk);
    @(negedge clk);
    check("R9 hold ch0", int'(smp_out[7:0]), ref_out('h12, 2, 1'b0, 1'b0));
    check("R9 hold ch1", int'(smp_out[15:8]), ref_out('h9A, 1, 1'b0, 1'b0));
    check("R9 out_valid low", int'(out_valid), 0);

    // R7: selector change while sync level stays high has no effect
    pad_ctrl = {2'd1, 2'd1};
    frame_sync = '1;
    @(negedge clk);
    pad_ctrl = {2'd3, 2'd3};
    @(negedge clk);
    strobe('h40, 'h40);
    check("R7 level ignored ch0", int'(smp_out[7:0]), ref_out('h40, 1, 1'b0, 1'b0));
    check("R7 level ignored ch1", int'(smp_out[15:8]), ref_out('h40, 1, 1'b0, 1'b0));
    frame_sync = '0;
    @(negedge clk);
    strobe('h41, 'h41);
    check("R7 no rise ch0", int'(smp_out[7:0]), ref_out('h41, 1, 1'b0, 1'b0));

    // R7: sync rise and strobe in the same cycle use the new selector
    law_sel = 1'b1;
    pad_ctrl = {2'd0, 2'd2};
    frame_sync = '1;
    strobe('h2A, 'h2A);
    frame_sync = '0;
    check("R7 same-cycle ch0", int'(smp_out[7:0]), ref_out('h2A, 2, 1'b1, 1'b0));
    check("R7 same-cycle ch1", int'(smp_out[15:8]), 'h2A);
    @(negedge clk);
    strobe('h2B, 'h2B);
    check("R7 kept ch0", int'(smp_out[7:0]), ref_out('h2B, 2, 1'b1, 1'b0));

    // R8 mute on every selector and law, including a same-cycle sync rise
    for (int a = 0; a < 2; a++) begin
      law_sel = 1'(a);
      for (int k = 0; k < 4; k++) begin
        pulse_sync(k, k);
        mute = 2'b01;
        strobe('h33 + k, 'h33 + k);
        mute = '0;
        check("R8 muted ch0", int'(smp_out[7:0]), a ? 'hD5 : 'hFF);
        check("R8 R10 unmuted ch1", int'(smp_out[15:8]), ref_out('h33 + k, k, 1'(a), 1'b0));
      end
      pad_ctrl = {2'd1, 2'd1};
      frame_sync = '1;
      mute = '1;
      strobe('h70, 'h70);
      mute = '0;
      frame_sync = '0;
      check("R8 mute with sync ch0", int'(smp_out[7:0]), a ? 'hD5 : 'hFF);
      check("R8 mute with sync ch1", int'(smp_out[15:8]), a ? 'hD5 : 'hFF);
      @(negedge clk);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule